// File: doc/BRIEF.md
# Two-Master Two-Slave AXI Crossbar

This block connects two AXI4 masters, a processor data port (master 0) and a copy-engine port (master 1), to two AXI4 slaves: a memory (slave 0) and a register block (slave 1). Each request address is decoded from its upper bits to pick a slave. The region base is cleared before the request is forwarded, so each slave only ever sees a local offset. An address outside both regions is answered inside the crossbar with a decode-error response and never reaches a slave.

Reads and writes go through two independent paths. Each path serves one transaction at a time. When both masters request in the same cycle, the lower-numbered master wins. The path records which master owns the transaction, and it returns read data and write responses only to that master. An INCR burst keeps the path until its last beat. The write path releases its grant after the B handshake, and the read path after the handshake of the last R beat. While a master holds RREADY or BREADY low, the response waits at the slave and is not lost.

Top module: `xbar_2m2s`

## Requirements
- R1: While reset is asserted, every valid and ready output of the crossbar on both sides is 0.
- R2: Addresses whose bits [31:16] equal 0 are routed to slave 0, and addresses whose bits [31:16] equal 1 are routed to slave 1. A request asserts the valid of at most one slave.
- R3: A forwarded address keeps bits [15:0] and carries zeros in bits [31:16].
- R4: When both masters assert a request on the same path in the same cycle, master 0 is served first and master 1 afterwards.
- R5: R and B responses are presented only to the master that issued the transaction. No other master sees RVALID or BVALID.
- R6: A burst of LEN+1 beats (LEN from 0 to 15) is routed in full, in order, and with its data intact. The last beat is flagged with RLAST.
- R7: While the owning master holds RREADY or BREADY low, RVALID or BVALID stays high with a stable payload, and no beat is lost.
- R8: The read and write paths run independently. A read and a write issued at the same time by different masters both complete correctly.
- R9: An address outside both regions completes with response code 2'b11 on every beat, with LEN+1 read beats and RLAST on the final beat. No slave sees a valid request for it.
- R10: A master's W beats are accepted only after the crossbar has accepted its AW. W from any other master sees WREADY low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_awvalid_i | input | NM | Master write-address valid |
| m_awready_o | output | NM | Master write-address ready |
| m_awaddr_i | input | NM x AW | Master write address |
| m_awlen_i | input | NM x LW | Master write burst length minus one |
| m_wvalid_i | input | NM | Master write-data valid |
| m_wready_o | output | NM | Master write-data ready |
| m_wdata_i | input | NM x DW | Master write data |
| m_wlast_i | input | NM | Master last write beat |
| m_bvalid_o | output | NM | Master write-response valid |
| m_bready_i | input | NM | Master write-response ready |
| m_bresp_o | output | NM x 2 | Master write-response code |
| m_arvalid_i | input | NM | Master read-address valid |
| m_arready_o | output | NM | Master read-address ready |
| m_araddr_i | input | NM x AW | Master read address |
| m_arlen_i | input | NM x LW | Master read burst length minus one |
| m_rvalid_o | output | NM | Master read-data valid |
| m_rready_i | input | NM | Master read-data ready |
| m_rdata_o | output | NM x DW | Master read data |
| m_rresp_o | output | NM x 2 | Master read-response code |
| m_rlast_o | output | NM | Master last read beat |
| s_awvalid_o | output | NS | Slave write-address valid |
| s_awready_i | input | NS | Slave write-address ready |
| s_awaddr_o | output | NS x AW | Slave local write address |
| s_awlen_o | output | NS x LW | Slave write burst length minus one |
| s_wvalid_o | output | NS | Slave write-data valid |
| s_wready_i | input | NS | Slave write-data ready |
| s_wdata_o | output | NS x DW | Slave write data |
| s_wlast_o | output | NS | Slave last write beat |
| s_bvalid_i | input | NS | Slave write-response valid |
| s_bready_o | output | NS | Slave write-response ready |
| s_bresp_i | input | NS x 2 | Slave write-response code |
| s_arvalid_o | output | NS | Slave read-address valid |
| s_arready_i | input | NS | Slave read-address ready |
| s_araddr_o | output | NS x AW | Slave local read address |
| s_arlen_o | output | NS x LW | Slave read burst length minus one |
| s_rvalid_i | input | NS | Slave read-data valid |
| s_rready_o | output | NS | Slave read-data ready |
| s_rdata_i | input | NS x DW | Slave read data |
| s_rresp_i | input | NS x 2 | Slave read-response code |
| s_rlast_i | input | NS | Slave last read beat |

## Verification
The hold checks on R and B assume that every slave obeys the usual valid/ready rule: once a response is valid, it stays valid with the same payload until it is accepted. They also assume that a slave returns exactly LEN+1 read beats with RLAST on the last one, and that masters keep AW, AR and W payloads stable until accepted and mark their final W beat. The bench slave models are register-driven and change RVALID, RDATA and BVALID only on a handshake. The bench master tasks drive each payload at a falling edge and hold it until they observe ready. Burst lengths stay within the 16-beat window that the slave models can address.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_DECERR = 2'b11;

  typedef enum logic [1:0] {RD_IDLE, RD_ADDR, RD_DATA} rd_state_e;
  typedef enum logic [1:0] {WR_IDLE, WR_ADDR, WR_DATA, WR_RESP} wr_state_e;
endpackage

// File: rtl/xbar_decode.sv
module xbar_decode #(
  parameter int AW       = 32,
  parameter int REGION_W = 16,
  parameter int NS       = 2,
  localparam int TW      = $clog2(NS + 1)
) (
  input  logic [AW-1:0] addr_i,
  output logic [TW-1:0] tgt_o,
  output logic [AW-1:0] local_o
);
  localparam int RW = AW - REGION_W;

  logic [RW-1:0] region;
  assign region  = addr_i[AW-1:REGION_W];
  // out-of-map requests get target index NS (decode error)
  assign tgt_o   = (region < RW'(NS)) ? TW'(region) : TW'(NS);
  assign local_o = {{RW{1'b0}}, addr_i[REGION_W-1:0]};
endmodule

// File: rtl/xbar_rd_path.sv
module xbar_rd_path import xbar_pkg::*; #(
  parameter int NM       = 2,
  parameter int NS       = 2,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LW       = 8,
  parameter int REGION_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NM-1:0]          m_arvalid_i,
  output logic [NM-1:0]          m_arready_o,
  input  logic [NM-1:0][AW-1:0]  m_araddr_i,
  input  logic [NM-1:0][LW-1:0]  m_arlen_i,
  output logic [NM-1:0]          m_rvalid_o,
  input  logic [NM-1:0]          m_rready_i,
  output logic [NM-1:0][DW-1:0]  m_rdata_o,
  output logic [NM-1:0][1:0]     m_rresp_o,
  output logic [NM-1:0]          m_rlast_o,
  output logic [NS-1:0]          s_arvalid_o,
  input  logic [NS-1:0]          s_arready_i,
  output logic [NS-1:0][AW-1:0]  s_araddr_o,
  output logic [NS-1:0][LW-1:0]  s_arlen_o,
  input  logic [NS-1:0]          s_rvalid_i,
  output logic [NS-1:0]          s_rready_o,
  input  logic [NS-1:0][DW-1:0]  s_rdata_i,
  input  logic [NS-1:0][1:0]     s_rresp_i,
  input  logic [NS-1:0]          s_rlast_i
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int TW = $clog2(NS + 1);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  rd_state_e      state_q;
  logic [MW-1:0]  owner_q, winner, sel;
  logic [TW-1:0]  tgt_q, dec_tgt;
  logic [SW-1:0]  tgt_idx;
  logic [AW-1:0]  dec_local;
  logic [LW-1:0]  len_q, cnt_q;
  logic           is_err, ar_hs, r_hs, r_last;

  // lowest index wins
  always_comb begin
    winner = '0;
    for (int i = NM - 1; i >= 0; i--) if (m_arvalid_i[i]) winner = MW'(i);
  end

  assign sel     = (state_q == RD_IDLE) ? winner : owner_q;
  assign tgt_idx = tgt_q[SW-1:0];
  assign is_err  = (tgt_q == TW'(NS));

  xbar_decode #(.AW(AW), .REGION_W(REGION_W), .NS(NS)) u_dec (
    .addr_i (m_araddr_i[sel]),
    .tgt_o  (dec_tgt),
    .local_o(dec_local)
  );

  always_comb begin
    m_arready_o = '0;
    s_arvalid_o = '0;
    m_rvalid_o  = '0;
    m_rdata_o   = '0;
    m_rresp_o   = '0;
    m_rlast_o   = '0;
    s_rready_o  = '0;
    ar_hs = 1'b0;
    r_hs  = 1'b0;
    r_last = 1'b0;
    for (int s = 0; s < NS; s++) begin
      s_araddr_o[s] = dec_local;
      s_arlen_o[s]  = m_arlen_i[owner_q];
    end
    case (state_q)
      RD_ADDR: begin
        if (is_err) begin
          m_arready_o[owner_q] = 1'b1;
          ar_hs = m_arvalid_i[owner_q];
        end else begin
          s_arvalid_o[tgt_idx] = m_arvalid_i[owner_q];
          m_arready_o[owner_q] = s_arready_i[tgt_idx];
          ar_hs = m_arvalid_i[owner_q] && s_arready_i[tgt_idx];
        end
      end
      RD_DATA: begin
        if (is_err) begin
          m_rvalid_o[owner_q] = 1'b1;
          m_rresp_o[owner_q]  = RESP_DECERR;
          m_rlast_o[owner_q]  = (cnt_q == len_q);
          r_hs   = m_rready_i[owner_q];
          r_last = (cnt_q == len_q);
        end else begin
          m_rvalid_o[owner_q] = s_rvalid_i[tgt_idx];
          m_rdata_o[owner_q]  = s_rdata_i[tgt_idx];
          m_rresp_o[owner_q]  = s_rresp_i[tgt_idx];
          m_rlast_o[owner_q]  = s_rlast_i[tgt_idx];
          s_rready_o[tgt_idx] = m_rready_i[owner_q];
          r_hs   = s_rvalid_i[tgt_idx] && m_rready_i[owner_q];
          r_last = s_rlast_i[tgt_idx];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RD_IDLE;
      owner_q <= '0;
      tgt_q   <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        RD_IDLE: if (|m_arvalid_i) begin
          owner_q <= winner;
          tgt_q   <= dec_tgt;
          state_q <= RD_ADDR;
        end
        RD_ADDR: if (ar_hs) begin
          len_q   <= m_arlen_i[owner_q];
          cnt_q   <= '0;
          state_q <= RD_DATA;
        end
        RD_DATA: if (r_hs) begin
          cnt_q <= cnt_q + 1'b1;
          if (r_last) state_q <= RD_IDLE;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  AST_R_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_rvalid_o)); // R5
  AST_AR_ONE_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_arvalid_o)); // R2
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_rvalid_o & ~m_rready_i) != '0) |=>
      (m_rvalid_o == $past(m_rvalid_o) && m_rdata_o == $past(m_rdata_o)
       && m_rlast_o == $past(m_rlast_o))); // R7
  AST_DECERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != RD_IDLE && is_err) |-> (s_arvalid_o == '0 && s_rready_o == '0)); // R9

  for (genvar s = 0; s < NS; s++) begin : g_ar_chk
    AST_AR_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_arvalid_o[s] |-> (s_araddr_o[s][AW-1:REGION_W] == '0)); // R3
  end
endmodule

// File: rtl/xbar_wr_path.sv
module xbar_wr_path import xbar_pkg::*; #(
  parameter int NM       = 2,
  parameter int NS       = 2,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LW       = 8,
  parameter int REGION_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NM-1:0]          m_awvalid_i,
  output logic [NM-1:0]          m_awready_o,
  input  logic [NM-1:0][AW-1:0]  m_awaddr_i,
  input  logic [NM-1:0][LW-1:0]  m_awlen_i,
  input  logic [NM-1:0]          m_wvalid_i,
  output logic [NM-1:0]          m_wready_o,
  input  logic [NM-1:0][DW-1:0]  m_wdata_i,
  input  logic [NM-1:0]          m_wlast_i,
  output logic [NM-1:0]          m_bvalid_o,
  input  logic [NM-1:0]          m_bready_i,
  output logic [NM-1:0][1:0]     m_bresp_o,
  output logic [NS-1:0]          s_awvalid_o,
  input  logic [NS-1:0]          s_awready_i,
  output logic [NS-1:0][AW-1:0]  s_awaddr_o,
  output logic [NS-1:0][LW-1:0]  s_awlen_o,
  output logic [NS-1:0]          s_wvalid_o,
  input  logic [NS-1:0]          s_wready_i,
  output logic [NS-1:0][DW-1:0]  s_wdata_o,
  output logic [NS-1:0]          s_wlast_o,
  input  logic [NS-1:0]          s_bvalid_i,
  output logic [NS-1:0]          s_bready_o,
  input  logic [NS-1:0][1:0]     s_bresp_i
);
  localparam int MW = (NM > 1) ? $clog2(NM) : 1;
  localparam int TW = $clog2(NS + 1);
  localparam int SW = (NS > 1) ? $clog2(NS) : 1;

  wr_state_e      state_q;
  logic [MW-1:0]  owner_q, winner, sel;
  logic [TW-1:0]  tgt_q, dec_tgt;
  logic [SW-1:0]  tgt_idx;
  logic [AW-1:0]  dec_local;
  logic           is_err, aw_hs, w_hs, w_last, b_hs;

  always_comb begin
    winner = '0;
    for (int i = NM - 1; i >= 0; i--) if (m_awvalid_i[i]) winner = MW'(i);
  end

  assign sel     = (state_q == WR_IDLE) ? winner : owner_q;
  assign tgt_idx = tgt_q[SW-1:0];
  assign is_err  = (tgt_q == TW'(NS));

  xbar_decode #(.AW(AW), .REGION_W(REGION_W), .NS(NS)) u_dec (
    .addr_i (m_awaddr_i[sel]),
    .tgt_o  (dec_tgt),
    .local_o(dec_local)
  );

  always_comb begin
    m_awready_o = '0;
    s_awvalid_o = '0;
    m_wready_o  = '0;
    s_wvalid_o  = '0;
    m_bvalid_o  = '0;
    m_bresp_o   = '0;
    s_bready_o  = '0;
    aw_hs  = 1'b0;
    w_hs   = 1'b0;
    w_last = m_wlast_i[owner_q];
    b_hs   = 1'b0;
    for (int s = 0; s < NS; s++) begin
      s_awaddr_o[s] = dec_local;
      s_awlen_o[s]  = m_awlen_i[owner_q];
      s_wdata_o[s]  = m_wdata_i[owner_q];
      s_wlast_o[s]  = m_wlast_i[owner_q];
    end
    case (state_q)
      WR_ADDR: begin
        if (is_err) begin
          m_awready_o[owner_q] = 1'b1;
          aw_hs = m_awvalid_i[owner_q];
        end else begin
          s_awvalid_o[tgt_idx] = m_awvalid_i[owner_q];
          m_awready_o[owner_q] = s_awready_i[tgt_idx];
          aw_hs = m_awvalid_i[owner_q] && s_awready_i[tgt_idx];
        end
      end
      // W opens only for the owner, after its AW was taken
      WR_DATA: begin
        if (is_err) begin
          m_wready_o[owner_q] = 1'b1;
          w_hs = m_wvalid_i[owner_q];
        end else begin
          s_wvalid_o[tgt_idx] = m_wvalid_i[owner_q];
          m_wready_o[owner_q] = s_wready_i[tgt_idx];
          w_hs = m_wvalid_i[owner_q] && s_wready_i[tgt_idx];
        end
      end
      WR_RESP: begin
        if (is_err) begin
          m_bvalid_o[owner_q] = 1'b1;
          m_bresp_o[owner_q]  = RESP_DECERR;
          b_hs = m_bready_i[owner_q];
        end else begin
          m_bvalid_o[owner_q] = s_bvalid_i[tgt_idx];
          m_bresp_o[owner_q]  = s_bresp_i[tgt_idx];
          s_bready_o[tgt_idx] = m_bready_i[owner_q];
          b_hs = s_bvalid_i[tgt_idx] && m_bready_i[owner_q];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WR_IDLE;
      owner_q <= '0;
      tgt_q   <= '0;
    end else begin
      case (state_q)
        WR_IDLE: if (|m_awvalid_i) begin
          owner_q <= winner;
          tgt_q   <= dec_tgt;
          state_q <= WR_ADDR;
        end
        WR_ADDR: if (aw_hs) state_q <= WR_DATA;
        WR_DATA: if (w_hs && w_last) state_q <= WR_RESP;
        WR_RESP: if (b_hs) state_q <= WR_IDLE;
        default: state_q <= WR_IDLE;
      endcase
    end
  end

  AST_B_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_bvalid_o)); // R5
  AST_W_ONE_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_wready_o)); // R10
  AST_AW_ONE_SLAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(s_awvalid_o)); // R2
  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((m_bvalid_o & ~m_bready_i) != '0) |=>
      (m_bvalid_o == $past(m_bvalid_o) && m_bresp_o == $past(m_bresp_o))); // R7
  AST_W_DECERR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != WR_IDLE && is_err) |-> (s_awvalid_o == '0 && s_wvalid_o == '0)); // R9

  for (genvar s = 0; s < NS; s++) begin : g_aw_chk
    AST_AW_LOCAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      s_awvalid_o[s] |-> (s_awaddr_o[s][AW-1:REGION_W] == '0)); // R3
  end
endmodule

// File: rtl/xbar_2m2s.sv
module xbar_2m2s #(
  parameter int NM       = 2,
  parameter int NS       = 2,
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int LW       = 8,
  parameter int REGION_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NM-1:0]          m_awvalid_i,
  output logic [NM-1:0]          m_awready_o,
  input  logic [NM-1:0][AW-1:0]  m_awaddr_i,
  input  logic [NM-1:0][LW-1:0]  m_awlen_i,
  input  logic [NM-1:0]          m_wvalid_i,
  output logic [NM-1:0]          m_wready_o,
  input  logic [NM-1:0][DW-1:0]  m_wdata_i,
  input  logic [NM-1:0]          m_wlast_i,
  output logic [NM-1:0]          m_bvalid_o,
  input  logic [NM-1:0]          m_bready_i,
  output logic [NM-1:0][1:0]     m_bresp_o,
  input  logic [NM-1:0]          m_arvalid_i,
  output logic [NM-1:0]          m_arready_o,
  input  logic [NM-1:0][AW-1:0]  m_araddr_i,
  input  logic [NM-1:0][LW-1:0]  m_arlen_i,
  output logic [NM-1:0]          m_rvalid_o,
  input  logic [NM-1:0]          m_rready_i,
  output logic [NM-1:0][DW-1:0]  m_rdata_o,
  output logic [NM-1:0][1:0]     m_rresp_o,
  output logic [NM-1:0]          m_rlast_o,
  output logic [NS-1:0]          s_awvalid_o,
  input  logic [NS-1:0]          s_awready_i,
  output logic [NS-1:0][AW-1:0]  s_awaddr_o,
  output logic [NS-1:0][LW-1:0]  s_awlen_o,
  output logic [NS-1:0]          s_wvalid_o,
  input  logic [NS-1:0]          s_wready_i,
  output logic [NS-1:0][DW-1:0]  s_wdata_o,
  output logic [NS-1:0]          s_wlast_o,
  input  logic [NS-1:0]          s_bvalid_i,
  output logic [NS-1:0]          s_bready_o,
  input  logic [NS-1:0][1:0]     s_bresp_i,
  output logic [NS-1:0]          s_arvalid_o,
  input  logic [NS-1:0]          s_arready_i,
  output logic [NS-1:0][AW-1:0]  s_araddr_o,
  output logic [NS-1:0][LW-1:0]  s_arlen_o,
  input  logic [NS-1:0]          s_rvalid_i,
  output logic [NS-1:0]          s_rready_o,
  input  logic [NS-1:0][DW-1:0]  s_rdata_i,
  input  logic [NS-1:0][1:0]     s_rresp_i,
  input  logic [NS-1:0]          s_rlast_i
);
  xbar_wr_path #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .LW(LW), .REGION_W(REGION_W)) u_wr (
    .clk_i, .rst_ni,
    .m_awvalid_i, .m_awready_o, .m_awaddr_i, .m_awlen_i,
    .m_wvalid_i, .m_wready_o, .m_wdata_i, .m_wlast_i,
    .m_bvalid_o, .m_bready_i, .m_bresp_o,
    .s_awvalid_o, .s_awready_i, .s_awaddr_o, .s_awlen_o,
    .s_wvalid_o, .s_wready_i, .s_wdata_o, .s_wlast_o,
    .s_bvalid_i, .s_bready_o, .s_bresp_i
  );

  xbar_rd_path #(.NM(NM), .NS(NS), .AW(AW), .DW(DW), .LW(LW), .REGION_W(REGION_W)) u_rd (
    .clk_i, .rst_ni,
    .m_arvalid_i, .m_arready_o, .m_araddr_i, .m_arlen_i,
    .m_rvalid_o, .m_rready_i, .m_rdata_o, .m_rresp_o, .m_rlast_o,
    .s_arvalid_o, .s_arready_i, .s_araddr_o, .s_arlen_o,
    .s_rvalid_i, .s_rready_o, .s_rdata_i, .s_rresp_i, .s_rlast_i
  );
endmodule

// File: tb/xbar_2m2s_test.sv
module xbar_2m2s_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]        m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
  logic [1:0][31:0]  m_awaddr, m_wdata, m_araddr, m_rdata;
  logic [1:0][7:0]   m_awlen, m_arlen;
  logic [1:0][1:0]   m_bresp, m_rresp;
  logic [1:0]        m_arvalid, m_arready, m_rvalid, m_rready, m_rlast;
  logic [1:0]        s_awvalid, s_awready, s_wvalid, s_wready, s_wlast, s_bvalid, s_bready;
  logic [1:0][31:0]  s_awaddr, s_wdata, s_araddr, s_rdata;
  logic [1:0][7:0]   s_awlen, s_arlen;
  logic [1:0][1:0]   s_bresp, s_rresp;
  logic [1:0]        s_arvalid, s_arready, s_rvalid, s_rready, s_rlast;

  xbar_2m2s uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_awvalid_i(m_awvalid), .m_awready_o(m_awready), .m_awaddr_i(m_awaddr), .m_awlen_i(m_awlen),
    .m_wvalid_i(m_wvalid), .m_wready_o(m_wready), .m_wdata_i(m_wdata), .m_wlast_i(m_wlast),
    .m_bvalid_o(m_bvalid), .m_bready_i(m_bready), .m_bresp_o(m_bresp),
    .m_arvalid_i(m_arvalid), .m_arready_o(m_arready), .m_araddr_i(m_araddr), .m_arlen_i(m_arlen),
    .m_rvalid_o(m_rvalid), .m_rready_i(m_rready), .m_rdata_o(m_rdata), .m_rresp_o(m_rresp),
    .m_rlast_o(m_rlast),
    .s_awvalid_o(s_awvalid), .s_awready_i(s_awready), .s_awaddr_o(s_awaddr), .s_awlen_o(s_awlen),
    .s_wvalid_o(s_wvalid), .s_wready_i(s_wready), .s_wdata_o(s_wdata), .s_wlast_o(s_wlast),
    .s_bvalid_i(s_bvalid), .s_bready_o(s_bready), .s_bresp_i(s_bresp),
    .s_arvalid_o(s_arvalid), .s_arready_i(s_arready), .s_araddr_o(s_araddr), .s_arlen_o(s_arlen),
    .s_rvalid_i(s_rvalid), .s_rready_o(s_rready), .s_rdata_i(s_rdata), .s_rresp_i(s_rresp),
    .s_rlast_i(s_rlast)
  );

  // slave models
  logic [31:0] mem [2][64];
  logic [1:0]  wbusy, bpend, rbusy;
  logic [1:0][31:0] wr_addr, rd_addr, last_awaddr, last_araddr;
  logic [1:0][7:0]  wbeat, rbeat, rd_len;
  int aw_cnt [2];
  int ar_cnt [2];

  for (genvar s = 0; s < 2; s++) begin : g_sl
    assign s_awready[s] = !wbusy[s];
    assign s_wready[s]  = wbusy[s] && !bpend[s];
    assign s_bvalid[s]  = bpend[s];
    assign s_bresp[s]   = 2'b00;
    assign s_arready[s] = !rbusy[s];
    assign s_rvalid[s]  = rbusy[s];
    assign s_rdata[s]   = mem[s][rd_addr[s][7:2] + rbeat[s][5:0]];
    assign s_rresp[s]   = 2'b00;
    assign s_rlast[s]   = rbusy[s] && (rbeat[s] == rd_len[s]);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbusy <= '0; bpend <= '0; rbusy <= '0;
      wbeat <= '0; rbeat <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (s_awvalid[s] && s_awready[s]) begin
          wbusy[s] <= 1'b1; wr_addr[s] <= s_awaddr[s]; wbeat[s] <= '0;
          last_awaddr[s] <= s_awaddr[s]; aw_cnt[s] <= aw_cnt[s] + 1;
        end
        if (s_wvalid[s] && s_wready[s]) begin
          mem[s][wr_addr[s][7:2] + wbeat[s][5:0]] <= s_wdata[s];
          wbeat[s] <= wbeat[s] + 8'd1;
          if (s_wlast[s]) bpend[s] <= 1'b1;
        end
        if (s_bvalid[s] && s_bready[s]) begin
          bpend[s] <= 1'b0; wbusy[s] <= 1'b0;
        end
        if (s_arvalid[s] && s_arready[s]) begin
          rbusy[s] <= 1'b1; rd_addr[s] <= s_araddr[s]; rd_len[s] <= s_arlen[s];
          rbeat[s] <= '0; last_araddr[s] <= s_araddr[s]; ar_cnt[s] <= ar_cnt[s] + 1;
        end
        if (s_rvalid[s] && s_rready[s]) begin
          rbeat[s] <= rbeat[s] + 8'd1;
          if (s_rlast[s]) rbusy[s] <= 1'b0;
        end
      end
    end
  end

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit [1:0] rd_act = '0, wr_act = '0, aw_done = '0;
  int stray = 0;
  int wstall_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R5 / R10 monitors
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      for (int m = 0; m < 2; m++) begin
        if ((m_rvalid[m] && !rd_act[m]) || (m_bvalid[m] && !wr_act[m])) stray++;
        if (m_wvalid[m] && m_wready[m] && !aw_done[m]) wstall_bad++;
      end
    end
  end

  task automatic mwrite(input int m, input logic [31:0] addr, input int len,
                        input logic [31:0] seed, input int bhold,
                        output logic [1:0] resp, output bit held);
    @(negedge clk);
    wr_act[m] = 1'b1;
    m_awvalid[m] = 1'b1; m_awaddr[m] = addr; m_awlen[m] = len[7:0];
    #1;
    while (!m_awready[m]) begin @(negedge clk); #1; end
    @(negedge clk);
    m_awvalid[m] = 1'b0;
    aw_done[m] = 1'b1;
    for (int b = 0; b <= len; b++) begin
      m_wvalid[m] = 1'b1; m_wdata[m] = seed + b; m_wlast[m] = (b == len);
      #1;
      while (!m_wready[m]) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    m_wvalid[m] = 1'b0; m_wlast[m] = 1'b0;
    aw_done[m] = 1'b0;
    held = 1'b1;
    if (bhold > 0) begin
      repeat (bhold) @(negedge clk);
      #1;
      held = m_bvalid[m];
    end
    m_bready[m] = 1'b1;
    #1;
    while (!m_bvalid[m]) begin @(negedge clk); #1; end
    resp = m_bresp[m];
    @(negedge clk);
    m_bready[m] = 1'b0;
    wr_act[m] = 1'b0;
  endtask

  task automatic mread(input int m, input logic [31:0] addr, input int len, input int rhold,
                       output logic [31:0] rd [16], output logic [1:0] resp_or,
                       output int beats, output bit held, output bit last_ok);
    bit lst;
    beats = 0; resp_or = '0; last_ok = 1'b1;
    @(negedge clk);
    rd_act[m] = 1'b1;
    m_arvalid[m] = 1'b1; m_araddr[m] = addr; m_arlen[m] = len[7:0];
    #1;
    while (!m_arready[m]) begin @(negedge clk); #1; end
    @(negedge clk);
    m_arvalid[m] = 1'b0;
    held = 1'b1;
    if (rhold > 0) begin
      repeat (rhold) @(negedge clk);
      #1;
      held = m_rvalid[m];
    end
    m_rready[m] = 1'b1;
    lst = 1'b0;
    while (!lst && beats < 40) begin
      #1;
      while (!m_rvalid[m]) begin @(negedge clk); #1; end
      rd[beats[3:0]] = m_rdata[m];
      resp_or |= m_rresp[m];
      lst = m_rlast[m];
      if (lst != (beats == len)) last_ok = 1'b0;
      beats++;
      @(negedge clk);
    end
    m_rready[m] = 1'b0;
    rd_act[m] = 1'b0;
  endtask

  // {master[3:0], addr[31:0], len[7:0], target[3:0]}; target 3 = unmapped
  localparam logic [47:0] VEC [7] = '{
    48'h0_00000040_03_0,
    48'h1_00010010_00_1,
    48'h0_00010080_07_1,
    48'h1_00000100_0F_0,
    48'h0_00020000_02_3,
    48'h1_80000000_00_3,
    48'h1_0000FFC0_01_0
  };

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [1:0]  wresp, rresp, wr0, wr1;
    logic [31:0] rbuf [16];
    logic [31:0] rbuf2 [16];
    int beats, beats2, first_w;
    bit held, lok, held2, lok2;

    m_awvalid = '0; m_wvalid = '0; m_wlast = '0; m_bready = '0;
    m_arvalid = '0; m_rready = '0;
    m_awaddr = '0; m_awlen = '0; m_wdata = '0; m_araddr = '0; m_arlen = '0;
    aw_cnt = '{0, 0}; ar_cnt = '{0, 0};

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({m_awready, m_wready, m_bvalid, m_arready, m_rvalid} == '0, "R1 master side",
        32'({m_awready, m_wready, m_bvalid, m_arready, m_rvalid}), 32'h0);
    chk({s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready} == '0, "R1 slave side",
        32'({s_awvalid, s_wvalid, s_bready, s_arvalid, s_rready}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 7; i++) begin
      automatic int m = int'(VEC[i][47:44]);
      automatic logic [31:0] addr = VEC[i][43:12];
      automatic int len = int'(VEC[i][11:4]);
      automatic int tg = int'(VEC[i][3:0]);
      automatic logic [31:0] seed = 32'hA000_0000 + 32'(i) * 32'h100;
      automatic int aw_pre0 = aw_cnt[0], aw_pre1 = aw_cnt[1];
      automatic int ar_pre0 = ar_cnt[0], ar_pre1 = ar_cnt[1];
      automatic int mism = 0;
      mwrite(m, addr, len, seed, 0, wresp, held);
      if (tg == 3) begin
        chk(wresp == 2'b11, "R9 write resp", 32'(wresp), 32'h3);
        chk(aw_cnt[0] == aw_pre0 && aw_cnt[1] == aw_pre1, "R9 no slave aw",
            32'(aw_cnt[0] + aw_cnt[1]), 32'(aw_pre0 + aw_pre1));
      end else begin
        chk(wresp == 2'b00, "R2 write resp", 32'(wresp), 32'h0);
        chk(aw_cnt[tg] == (tg == 0 ? aw_pre0 : aw_pre1) + 1, "R2 write routed",
            32'(aw_cnt[tg]), 32'((tg == 0 ? aw_pre0 : aw_pre1) + 1));
        chk(last_awaddr[tg] == {16'h0, addr[15:0]}, "R3 write local addr",
            last_awaddr[tg], {16'h0, addr[15:0]});
      end
      mread(m, addr, len, 0, rbuf, rresp, beats, held, lok);
      chk(beats == len + 1, "R6 beat count", 32'(beats), 32'(len + 1));
      chk(lok, "R6 rlast on final beat", 32'(lok), 32'h1);
      if (tg == 3) begin
        chk(rresp == 2'b11, "R9 read resp", 32'(rresp), 32'h3);
        chk(ar_cnt[0] == ar_pre0 && ar_cnt[1] == ar_pre1, "R9 no slave ar",
            32'(ar_cnt[0] + ar_cnt[1]), 32'(ar_pre0 + ar_pre1));
      end else begin
        chk(rresp == 2'b00, "R2 read resp", 32'(rresp), 32'h0);
        chk(last_araddr[tg] == {16'h0, addr[15:0]}, "R3 read local addr",
            last_araddr[tg], {16'h0, addr[15:0]});
        for (int b = 0; b <= len; b++) if (rbuf[b] != seed + 32'(b)) mism++;
        chk(mism == 0, "R6 burst data", 32'(mism), 32'h0);
      end
    end

    // R4: simultaneous writes to one location; master 0 first, master 1 last
    first_w = -1;
    fork
      begin mwrite(0, 32'h0000_0200, 0, 32'h1111_0000, 0, wr0, held); if (first_w < 0) first_w = 0; end
      begin mwrite(1, 32'h0000_0200, 0, 32'h2222_0000, 0, wr1, held2); if (first_w < 0) first_w = 1; end
    join
    chk(first_w == 0, "R4 master 0 served first", 32'(first_w), 32'h0);
    mread(0, 32'h0000_0200, 0, 0, rbuf, rresp, beats, held, lok);
    chk(rbuf[0] == 32'h2222_0000, "R4 master 1 written last", rbuf[0], 32'h2222_0000);

    // R7: response backpressure
    mwrite(0, 32'h0001_0020, 1, 32'hB000_0000, 4, wresp, held);
    chk(held, "R7 bvalid held while bready low", 32'(held), 32'h1);
    chk(wresp == 2'b00, "R7 write resp after hold", 32'(wresp), 32'h0);
    mread(1, 32'h0001_0020, 1, 4, rbuf, rresp, beats, held, lok);
    chk(held, "R7 rvalid held while rready low", 32'(held), 32'h1);
    chk(beats == 2 && rbuf[0] == 32'hB000_0000 && rbuf[1] == 32'hB000_0001,
        "R7 no beat lost", rbuf[1], 32'hB000_0001);

    // R8: concurrent write (m0) and read (m1)
    fork
      mwrite(0, 32'h0000_0300, 3, 32'hC000_0000, 0, wresp, held);
      mread(1, 32'h0000_0040, 3, 0, rbuf2, rresp, beats2, held2, lok2);
    join
    chk(wresp == 2'b00, "R8 concurrent write resp", 32'(wresp), 32'h0);
    chk(beats2 == 4 && rbuf2[3] == 32'hA000_0003, "R8 concurrent read data", rbuf2[3], 32'hA000_0003);
    mread(0, 32'h0000_0300, 3, 0, rbuf, rresp, beats, held, lok);
    chk(rbuf[3] == 32'hC000_0003, "R8 concurrent write landed", rbuf[3], 32'hC000_0003);

    // R10: master 1 drives W without AW while master 0 writes
    @(negedge clk);
    m_wvalid[1] = 1'b1; m_wdata[1] = 32'hDEAD_BEEF; m_wlast[1] = 1'b1;
    mwrite(0, 32'h0000_0380, 2, 32'hD000_0000, 0, wresp, held);
    chk(m_wready[1] == 1'b0, "R10 stray W not ready", 32'(m_wready[1]), 32'h0);
    m_wvalid[1] = 1'b0; m_wlast[1] = 1'b0;
    mread(0, 32'h0000_0380, 2, 0, rbuf, rresp, beats, held, lok);
    chk(rbuf[0] == 32'hD000_0000 && rbuf[2] == 32'hD000_0002, "R10 stray W not written",
        rbuf[0], 32'hD000_0000);
    chk(wstall_bad == 0, "R10 W accepted only after AW", 32'(wstall_bad), 32'h0);
    chk(stray == 0, "R5 responses only to owner", 32'(stray), 32'h0);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule